// File: doc/BRIEF.md
# Fractional 3/13 Clock Divider

This block turns a fast reference clock into a slower square-wave output and a matching clock-enable strobe. The output completes three periods for every thirteen reference clocks, so its average rate is 3/13 of the input. A 16 MHz reference therefore gives about 3.6923 MHz. That is +0.16% from the common 3.6864 MHz serial reference, which is well inside the timing tolerance of asynchronous serial links.

No integer divider yields the 13/3 ratio. The block gets it from a phase accumulator that adds 3 modulo 13 on every enabled clock. The accumulator wraps after 4, 4 and then 5 clocks. Each wrap starts a new output period, and the output stays high for the first two clocks of that period. Downstream logic can be clocked from the reference and qualified by the strobe. It then never needs a second clock domain.

Top module: `frac_clk_div`

## Requirements
- R1: Over every run of 13 enabled clocks counted from reset release (clocks 1..13, 14..26, ...), the strobe pulses exactly 3 times.
- R2: The first output rising edge is registered on the 4th enabled clock after reset release. The k-th rise (k >= 2) follows the previous one by 5 enabled clocks when k is a multiple of 3, and by 4 enabled clocks otherwise. The spacing is therefore 4, 4, 5, repeating.
- R3: Output falling edges have the same spacing as the rises. The first fall is on enabled clock 6, and the k-th fall (k >= 2) follows the previous fall by 5 enabled clocks when k is a multiple of 3, and by 4 otherwise.
- R4: In each output period, `clk_o` is 1 for exactly 2 enabled clocks, starting at the rise, and 0 for the remaining clocks of that period.
- R5: `stb_o` is 1 for exactly one clock, on the same clock in which `clk_o` rises, and is 0 at all other times.
- R6: While `rst_ni` is 0, `clk_o` and `stb_o` are 0 and the phase returns to the start of the 4-4-5 sequence. Reset acts asynchronously.
- R7: On a clock where `en_i` is 0, `clk_o` and the phase hold their values and `stb_o` is 0. When `en_i` returns to 1, the sequence resumes from the same phase.
- R8: Let t_k be the enabled-clock index of the k-th rise. Then 3*t_k - 13*k + 1 lies in [-1, 1]. In other words, no edge is more than 1/3 clock away from a 13/3-spaced ideal grid.
- R9: Two consecutive rise-to-rise intervals differ by at most one clock, so the peak-to-peak cycle-to-cycle jitter is one input clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Advance enable; when 0, the phase and the output hold |
| clk_o | output | 1 | Divided output, registered |
| stb_o | output | 1 | One-clock pulse on each rise of `clk_o` |

## Verification
The assertions check the following on every cycle:
- the accumulator stays inside its modulus;
- two enabled wraps are never adjacent;
- the strobe and the output rise occur together;
- the output stays high on the clock after a rise;
- the output and the strobe respond correctly to `en_i` going low.

Three properties span whole periods and groups of edges. These are the 4-4-5 spacing, the three edges in every thirteen clocks, and the bound on displacement from the 13/3 grid. Only the bench scenarios show these. They run long enabled stretches, irregular enable patterns, idle gaps and a reset in mid-sequence, all against a behavioural model that counts enabled clocks.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned DEF_NUM      = 3;
  localparam int unsigned DEF_DEN      = 13;
  localparam int unsigned DEF_HIGH_CYC = 2;
  // Start phase chosen so the wraps fall on clocks 4, 8, 13.
  localparam int unsigned DEF_ACC_INIT = 2;

  function automatic int unsigned acc_width(input int unsigned num, input int unsigned den);
    return $clog2(num + den);
  endfunction
endpackage

// File: rtl/frac_div_accum.sv
module frac_div_accum
  import frac_div_pkg::*;
#(
  parameter int unsigned NUM      = DEF_NUM,
  parameter int unsigned DEN      = DEF_DEN,
  parameter int unsigned ACC_INIT = DEF_ACC_INIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic wrap_o
);
  localparam int unsigned ACC_W = acc_width(NUM, DEN);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] acc_d;

  assign sum    = acc_q + ACC_W'(NUM);
  assign wrap_o = (sum >= ACC_W'(DEN));
  assign acc_d  = wrap_o ? (sum - ACC_W'(DEN)) : sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= ACC_W'(ACC_INIT);
    else if (en_i) acc_q <= acc_d;
  end

  // R1: phase stays inside the modulus
  p_acc_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < ACC_W'(DEN));

  // R2: at least 2 clocks between enabled wraps (NUM < DEN/2)
  p_wrap_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && en_i) |=> !wrap_o);

  // R7: phase frozen while idle
  p_acc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));
endmodule

// File: rtl/frac_div_shape.sv
module frac_div_shape
  import frac_div_pkg::*;
#(
  parameter int unsigned HIGH_CYC = DEF_HIGH_CYC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic wrap_i,
  output logic clk_o,
  output logic stb_o
);
  localparam int unsigned HC_W = $clog2(HIGH_CYC + 1);

  logic [HC_W-1:0] hcnt_q;

  // HIGH_CYC must stay below floor(DEN/NUM) so each high phase ends before the next wrap.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_o  <= 1'b0;
      stb_o  <= 1'b0;
      hcnt_q <= '0;
    end else if (!en_i) begin
      stb_o  <= 1'b0;
    end else if (wrap_i) begin
      clk_o  <= 1'b1;
      stb_o  <= 1'b1;
      hcnt_q <= HC_W'(HIGH_CYC - 1);
    end else begin
      stb_o  <= 1'b0;
      if (hcnt_q != '0) hcnt_q <= hcnt_q - 1'b1;
      else              clk_o  <= 1'b0;
    end
  end

  p_stb_on_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> $rose(clk_o));

  p_rise_has_stb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_o) |-> stb_o);

  p_stb_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);

  p_high_two_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> clk_o);

  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(clk_o) && !stb_o));
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
#(
  parameter int unsigned NUM      = DEF_NUM,
  parameter int unsigned DEN      = DEF_DEN,
  parameter int unsigned HIGH_CYC = DEF_HIGH_CYC,
  parameter int unsigned ACC_INIT = DEF_ACC_INIT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o,
  output logic stb_o
);
  logic wrap;

  frac_div_accum #(
    .NUM      (NUM),
    .DEN      (DEN),
    .ACC_INIT (ACC_INIT)
  ) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .wrap_o (wrap)
  );

  frac_div_shape #(
    .HIGH_CYC (HIGH_CYC)
  ) u_shape (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .wrap_i (wrap),
    .clk_o  (clk_o),
    .stb_o  (stb_o)
  );

  // R6: nothing toggles in the first clock after reset release
  p_reset_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!clk_o && !stb_o));
endmodule

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic clk_o;
  logic stb_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // model state
  int n = 0;          // enabled clocks since reset release
  int k = 0;          // rises seen
  int kf = 0;         // falls seen
  int last_rise = 0;
  int last_fall = 0;
  int prev_iv = 0;
  int grp_edges = 0;
  bit prev_out = 1'b0;
  logic [15:0] lfsr = 16'hace1;

  frac_clk_div u_frac_clk_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .clk_o  (clk_o),
    .stb_o  (stb_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic bit edge_at(input int m);
    if (m < 1) return 1'b0;
    return ((2 + 3 * m) / 13) != ((2 + 3 * (m - 1)) / 13);
  endfunction

  function automatic int exp_iv(input int idx);
    return (idx % 3 == 0) ? 5 : 4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d (n=%0d)", tag, act, exp, n);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic model_reset();
    n = 0; k = 0; kf = 0; last_rise = 0; last_fall = 0;
    prev_iv = 0; grp_edges = 0; prev_out = 1'b0;
  endtask

  // entered and left at a negedge
  task automatic step(input logic en);
    bit exp_out;
    bit exp_stb;
    int iv;
    int d;
    en_i = en;
    @(posedge clk_i);
    if (en) n++;
    exp_stb = en && edge_at(n);
    exp_out = edge_at(n) || edge_at(n - 1);
    @(negedge clk_i);
    if (en) begin
      chk("R4 clk_o level", int'(clk_o), int'(exp_out));
      chk("R5 stb_o pulse", int'(stb_o), int'(exp_stb));
    end else begin
      chk("R7 clk_o hold", int'(clk_o), int'(exp_out));
      chk("R7 stb_o idle", int'(stb_o), 0);
    end
    if (stb_o) begin
      k++;
      grp_edges++;
      iv = n - last_rise;
      if (k == 1) chk("R2 first rise", n, 4);
      else        chk("R2 rise spacing", iv, exp_iv(k));
      d = 3 * n - 13 * k + 1;
      chk("R8 grid displacement ok", int'(d >= -1 && d <= 1), 1);
      if (k >= 3) chk("R9 jitter ok", int'((iv - prev_iv) <= 1 && (prev_iv - iv) <= 1), 1);
      prev_iv = iv;
      last_rise = n;
    end
    if (prev_out && !clk_o) begin
      kf++;
      if (kf == 1) chk("R3 first fall", n, 6);
      else         chk("R3 fall spacing", n - last_fall, exp_iv(kf));
      last_fall = n;
    end
    if (en && n > 0 && n % 13 == 0) begin
      chk("R1 rises per 13", grp_edges, 3);
      grp_edges = 0;
    end
    prev_out = clk_o;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    chk("R6 clk_o in reset", int'(clk_o), 0);
    chk("R6 stb_o in reset", int'(stb_o), 0);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R6 clk_o held reset", int'(clk_o), 0);
    model_reset();
    rst_ni = 1'b1;
  endtask

  initial begin
    @(negedge clk_i);
    do_reset();
    for (int i = 0; i < 130; i++) step(1'b1);
    // irregular enable
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3]);
    end
    // reset in mid-sequence, asynchronous to the edge
    for (int i = 0; i < 7; i++) step(1'b1);
    #2;
    do_reset();
    for (int i = 0; i < 60; i++) step(1'b1);
    // long idle gaps at every phase
    for (int g = 0; g < 13; g++) begin
      for (int i = 0; i < g + 1; i++) step(1'b1);
      for (int i = 0; i < 20; i++) step(1'b0);
    end
    for (int i = 0; i < 200; i++) step(1'b1);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule